// File: doc/BRIEF.md
# Power-Up Recall and Brown-Out Supervisor

This clocked supervisor watches three supply-level flags. External comparators produce them: below-reset, below-inhibit and above-switch. From these flags it decides when the nonvolatile contents must be copied back into the SRAM array, and when copies into nonvolatile storage must be blocked. A power-on, or any drop of the supply under the reset level, latches a recall request. When the supply next climbs past the switch level, the supervisor issues a one-cycle start pulse to the store/recall controller. It then keeps SRAM access closed for a restore window of `RESTORE_CYCLES` clocks.

A shallow brown-out leaves the supply above the reset level. It raises the store-inhibit line for as long as it lasts, but it does not request a recall. All three flags are asynchronous, and each passes through a two-stage synchronizer before any decision uses it. Once a start has fired, the request is spent. Chatter on the switch flag therefore cannot start a second recall. Only a new deep drop can request one.

Top module: `pwr_recall_sup`

## Requirements
- R1: While rst_ni is low, and until the synchronized flags change, store_inhibit_o is 1 and recall_start_o, recall_busy_o and sram_ready_o are 0. A recall request is pending out of reset.
- R2: sram_ready_o is 1 only when the synchronized above-switch flag is 1, no recall request is pending and no recall is running. A dip below the switch level alone drops it without raising store_inhibit_o.
- R3: recall_start_o is a single-cycle pulse that coincides with the first cycle of recall_busy_o. It fires on the third rising edge after above_switch_i rises, provided a request is pending and the below-reset flag is low.
- R4: recall_busy_o stays 1 for exactly RESTORE_CYCLES clock cycles after the start, unless it is aborted. sram_ready_o rises in the cycle after it falls.
- R5: store_inhibit_o is 1 whenever the synchronized below-inhibit or below-reset flag is 1, or a recall is running.
- R6: A dip that stays above the reset level holds store_inhibit_o at 1 for its whole length. It requests no recall when the supply comes back.
- R7: The request is set by the below-reset flag and is held until a start consumes it. A supply that rises past the reset and inhibit levels but not past the switch level starts nothing.
- R8: A below-reset flag during a recall ends recall_busy_o on the third edge after the flag rises and re-latches the request. A full recall follows when the supply returns above switch.
- R9: Each request yields at most one start. Toggling above_switch_i during or after a recall produces no further start pulse.
- R10: A flag change reaches the outputs after exactly two rising edges. After one edge the outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| below_reset_i | input | 1 | Comparator flag: supply under the reset level (asynchronous) |
| below_inhibit_i | input | 1 | Comparator flag: supply under the store-inhibit level (asynchronous) |
| above_switch_i | input | 1 | Comparator flag: supply over the switch level (asynchronous) |
| store_inhibit_o | output | 1 | Blocks nonvolatile store operations |
| recall_start_o | output | 1 | One-cycle pulse that launches the automatic recall |
| recall_busy_o | output | 1 | Restore window in progress |
| sram_ready_o | output | 1 | SRAM access may proceed |

## Verification
The supply is driven through four profiles:
- A clean power-up.
- A shallow dip under the inhibit level.
- A dip under the switch level only.
- A deep drop under the reset level, followed by a staged return.

Comparing these profiles separates the events that must start a recall from those that only inhibit stores or only drop ready. A deep drop during a running recall tests the abort and re-latch path. One-cycle pulses on the switch flag, both during and after a restore, show whether a spent request can fire twice. Checks one edge and two edges after a flag change pin down the synchronizer latency, and checks at the last busy cycle pin down the restore length.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;
  localparam int unsigned NUM_FLAGS = 3;

  typedef struct packed {
    logic below_reset;
    logic below_inhibit;
    logic above_switch;
  } sup_flags_t;

  // Power-on assumption: supply is low until the comparators say otherwise
  localparam sup_flags_t FLAGS_RST = '{below_reset: 1'b1, below_inhibit: 1'b1, above_switch: 1'b0};
endpackage

// File: rtl/pwr_flag_sync.sv
module pwr_flag_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);
  logic [STAGES-1:0][WIDTH-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) sync_q[i] <= RST_VAL;
    end else begin
      sync_q[0] <= din_i;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign dout_o = sync_q[STAGES-1];
endmodule

// File: rtl/pwr_restore_timer.sv
module pwr_restore_timer #(
  parameter int unsigned CYCLES = 110000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic abort_i,
  output logic busy_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (abort_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= LOAD_VAL;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/pwr_recall_sup.sv
module pwr_recall_sup
  import pwr_sup_pkg::*;
#(
  parameter int unsigned RESTORE_CYCLES = 110000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic below_reset_i,
  input  logic below_inhibit_i,
  input  logic above_switch_i,
  output logic store_inhibit_o,
  output logic recall_start_o,
  output logic recall_busy_o,
  output logic sram_ready_o
);
  sup_flags_t flags_raw, flags_s;
  logic       req_q, start_q, busy, go, abort;

  assign flags_raw = '{below_reset: below_reset_i, below_inhibit: below_inhibit_i,
                       above_switch: above_switch_i};

  pwr_flag_sync #(
    .WIDTH  (NUM_FLAGS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(FLAGS_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .din_i (flags_raw),
    .dout_o(flags_s)
  );

  // Between the reset and switch levels the request keeps its value: only a
  // deep drop re-arms it, so switch-flag chatter cannot fire a second recall.
  assign go    = req_q & flags_s.above_switch & ~flags_s.below_reset & ~busy;
  assign abort = flags_s.below_reset;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b1;
      start_q <= 1'b0;
    end else begin
      start_q <= go;
      if (flags_s.below_reset) req_q <= 1'b1;
      else if (go)             req_q <= 1'b0;
    end
  end

  pwr_restore_timer #(
    .CYCLES(RESTORE_CYCLES)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (go),
    .abort_i(abort),
    .busy_o (busy)
  );

  assign store_inhibit_o = flags_s.below_inhibit | flags_s.below_reset | busy;
  assign recall_start_o  = start_q;
  assign recall_busy_o   = busy;
  assign sram_ready_o    = flags_s.above_switch & ~req_q & ~busy;
endmodule

// File: rtl/pwr_recall_sup_chk.sv
module pwr_recall_sup_chk #(
  parameter int unsigned RESTORE_CYCLES = 110000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sw_sync_i,
  input logic store_inhibit_o,
  input logic recall_start_o,
  input logic recall_busy_o,
  input logic sram_ready_o
);
  localparam int unsigned RW = $clog2(RESTORE_CYCLES + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_q <= '0;
    else if (recall_busy_o) run_q <= (run_q == RW'(RESTORE_CYCLES + 1)) ? run_q : run_q + 1'b1;
    else                    run_q <= '0;
  end

  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_start_o |=> !recall_start_o); // R3
  AST_START_WITH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_start_o |-> recall_busy_o); // R3
  AST_BUSY_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(recall_busy_o) |-> recall_start_o); // R9
  AST_READY_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_ready_o |-> (sw_sync_i && !recall_busy_o && !store_inhibit_o)); // R2
  AST_BUSY_INHIBITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_busy_o |-> store_inhibit_o); // R5
  AST_RESTORE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RW'(RESTORE_CYCLES)); // R4
endmodule

bind pwr_recall_sup pwr_recall_sup_chk #(.RESTORE_CYCLES(RESTORE_CYCLES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sw_sync_i      (flags_s.above_switch),
  .store_inhibit_o(store_inhibit_o),
  .recall_start_o (recall_start_o),
  .recall_busy_o  (recall_busy_o),
  .sram_ready_o   (sram_ready_o)
);

// File: tb/pwr_recall_sup_tb.sv
`timescale 1ns/1ps
module pwr_recall_sup_tb;
  localparam int unsigned N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic b_rst = 1'b1, b_inh = 1'b1, a_sw = 1'b0;
  logic inh_o, start_o, busy_o, rdy_o;

  typedef struct {
    string      tag;
    logic [3:0] exp; // {inhibit, start, busy, ready}
  } item_t;

  item_t q[$];
  int    checks = 0, fails = 0;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_recall_sup #(.RESTORE_CYCLES(N)) u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .below_reset_i  (b_rst),
    .below_inhibit_i(b_inh),
    .above_switch_i (a_sw),
    .store_inhibit_o(inh_o),
    .recall_start_o (start_o),
    .recall_busy_o  (busy_o),
    .sram_ready_o   (rdy_o)
  );

  task automatic expect_out(string tag, logic inh, logic st, logic bsy, logic rdy);
    item_t it;
    it.tag = tag;
    it.exp = {inh, st, bsy, rdy};
    q.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor: compares queued expectations mid-cycle, away from the edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [3:0] act;
      it  = q.pop_front();
      act = {inh_o, start_o, busy_o, rdy_o};
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual inh/start/busy/ready=%b expected=%b", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1;
    expect_out("R1 in reset", 1, 0, 0, 0);
    tick(3);
    rst_n = 1'b1;
    tick(1);
    expect_out("R1 after release", 1, 0, 0, 0);

    // Power-up: past reset and inhibit levels, switch not yet
    b_rst = 1'b0; b_inh = 1'b0;
    tick(1);
    expect_out("R10 one edge", 1, 0, 0, 0);
    tick(1);
    expect_out("R10 two edges", 0, 0, 0, 0);
    tick(4);
    expect_out("R7 no switch no start", 0, 0, 0, 0);

    a_sw = 1'b1;
    tick(2);
    expect_out("R3 before start", 0, 0, 0, 0);
    tick(1);
    expect_out("R3 start pulse", 1, 1, 1, 0);
    tick(1);
    expect_out("R3 pulse ends", 1, 0, 1, 0);
    tick(N - 2);
    expect_out("R4 last busy cycle", 1, 0, 1, 0);
    tick(1);
    expect_out("R4 restore done ready", 0, 0, 0, 1);

    // Switch chatter after the recall
    a_sw = 1'b0; tick(1); a_sw = 1'b1; tick(4);
    expect_out("R9 no second start", 0, 0, 0, 1);

    // Shallow brown-out
    b_inh = 1'b1; a_sw = 1'b0;
    tick(2);
    expect_out("R6 dip inhibits", 1, 0, 0, 0);
    tick(10);
    expect_out("R6 dip held", 1, 0, 0, 0);
    b_inh = 1'b0; a_sw = 1'b1;
    tick(2);
    expect_out("R6 dip recovered", 0, 0, 0, 1);
    tick(2);
    expect_out("R6 no recall after dip", 0, 0, 0, 1);

    // Dip below switch only
    a_sw = 1'b0;
    tick(2);
    expect_out("R2 below switch", 0, 0, 0, 0);
    a_sw = 1'b1;
    tick(2);
    expect_out("R2 back above switch", 0, 0, 0, 1);

    // Deep drop, staged return
    b_rst = 1'b1; b_inh = 1'b1; a_sw = 1'b0;
    tick(2);
    expect_out("R5 deep drop", 1, 0, 0, 0);
    tick(3);
    b_rst = 1'b0;
    tick(2);
    expect_out("R7 latched above reset", 1, 0, 0, 0);
    b_inh = 1'b0;
    tick(2);
    expect_out("R7 pending below switch", 0, 0, 0, 0);
    a_sw = 1'b1;
    tick(3);
    expect_out("R7 recall starts", 1, 1, 1, 0);
    tick(1);
    expect_out("R4 busy running", 1, 0, 1, 0);
    a_sw = 1'b0; tick(1); a_sw = 1'b1; tick(2);
    expect_out("R9 no restart in restore", 1, 0, 1, 0);

    // Deep drop during the restore
    b_rst = 1'b1; b_inh = 1'b1; a_sw = 1'b0;
    tick(2);
    expect_out("R8 before abort", 1, 0, 1, 0);
    tick(1);
    expect_out("R8 aborted", 1, 0, 0, 0);
    b_rst = 1'b0; b_inh = 1'b0; a_sw = 1'b1;
    tick(2);
    expect_out("R8 request relatched", 0, 0, 0, 0);
    tick(1);
    expect_out("R8 recall again", 1, 1, 1, 0);
    tick(N);
    expect_out("R4 second restore done", 0, 0, 0, 1);

    tick(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule